// File: doc/BRIEF.md
# Sequencer Counter and Branch Unit

This block handles the control-flow side of a small bit-manipulation microsequencer. Each enabled cycle it takes one decoded instruction and updates its program counter and one of two 16-bit counters, A and B. It can run a counted loop, branch on a selected source bit, add an immediate, load an immediate, or load or add a 16-bit value taken from the upper half of the word most recently sent to the output register. Any counter write can be limited to the high byte, the low byte, or both.

The surrounding sequencer supplies the decoded fields, the already-selected source bit and the fed-back upper output bits. It reads the program counter as the instruction-memory index for the next instruction. Instruction fetch, the data path and the lookup table live elsewhere.

Top module: `seq_ctl_unit`

## Requirements
- R1: After reset, `pc`, `cnt_a` and `cnt_b` are all zero.
- R2: While `step` is low, `pc`, `cnt_a` and `cnt_b` keep their values whatever the other inputs are.
- R3: The `op` field is 3 bits: 0 = add immediate, 1 = branch if bit set, 2 = branch if bit clear, 3 = load immediate, 4 = load from output bits, 5 = add output bits, 6 = loop, 7 = no operation. When a step does not branch, `pc` becomes `pc + 1`, wrapping modulo 2^PC_W.
- R4: On op 1 the next `pc` is `target` when `src_bit` is 1. On op 2 it is `target` when `src_bit` is 0. Otherwise it is `pc + 1`.
- R5: On op 6 the selected counter is compared with `imm_a` as an unsigned number, using its value before this step. If it is smaller, `imm_b` is added to the full 16-bit counter modulo 2^16 and `pc` becomes `target`. If not, the counter is unchanged and `pc` advances. `hsel` and `lsel` have no effect on op 6.
- R6: On op 0 `imm_a` is added to the selected counter. With both lane flags set, the add is a full 16-bit add modulo 2^16.
- R7: On op 3 `imm_a` is written into the enabled byte lanes of the selected counter.
- R8: On op 4 `out_hi` is written into the enabled byte lanes of the selected counter.
- R9: On op 5 `out_hi` is added to the selected counter. The full and lane rules are the same as for op 0.
- R10: `hsel` enables the upper byte [15:8] and `lsel` enables the lower byte [7:0]. With only one flag set, that byte alone is updated. An add then wraps modulo 256 within the byte, with no carry into the other byte, and the other byte is unchanged. With neither flag set, ops 0, 3, 4 and 5 leave the counter unchanged.
- R11: `csel` = 1 selects counter B and `csel` = 0 selects counter A. The unselected counter never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Execute the presented instruction this cycle |
| op | input | 3 | Operation code |
| csel | input | 1 | Counter select: 1 = B, 0 = A |
| hsel | input | 1 | Upper byte lane enable |
| lsel | input | 1 | Lower byte lane enable |
| imm_a | input | 16 | Add or load immediate; loop limit |
| imm_b | input | 16 | Loop increment |
| target | input | PC_W | Absolute branch target |
| src_bit | input | 1 | Selected source bit for the conditional branches |
| out_hi | input | 16 | Upper 16 bits of the value sent to the output register |
| pc | output | PC_W | Program counter, the index of the next instruction |
| cnt_a | output | 16 | Counter A |
| cnt_b | output | 16 | Counter B |

## Verification
A taken loop updates a counter and branches in one cycle, and the compare must use the counter value from before that update. Directed loops start just below the limit and at the limit, and the checks confirm that the jump and the increment happen together or not at all. Random instruction streams also mix counter selection, lane flags and stalled steps. The bench model predicts the program counter and both counters after every step.

// File: rtl/seq_ctl_unit.sv
module seq_ctl_unit #(
  parameter int CNT_W = 16,
  parameter int PC_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [2:0]       op,
  input  logic             csel,
  input  logic             hsel,
  input  logic             lsel,
  input  logic [CNT_W-1:0] imm_a,
  input  logic [CNT_W-1:0] imm_b,
  input  logic [PC_W-1:0]  target,
  input  logic             src_bit,
  input  logic [CNT_W-1:0] out_hi,
  output logic [PC_W-1:0]  pc,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b
);
  localparam int LW = CNT_W / 2;
  localparam logic [2:0] OP_ADD = 3'd0, OP_IF = 3'd1, OP_IFN = 3'd2,
                         OP_LDD = 3'd3, OP_LDI = 3'd4, OP_ADI = 3'd5,
                         OP_LOOP = 3'd6;

  logic [CNT_W-1:0] cur, opnd, full, lane_add, lane_ld, nxt;
  logic [LW-1:0]    sum_hi, sum_lo;
  logic             is_add, is_ld, loop_go, wr, jump;

  assign cur    = csel ? cnt_b : cnt_a;
  assign is_add = (op == OP_ADD) || (op == OP_ADI);
  assign is_ld  = (op == OP_LDD) || (op == OP_LDI);

  always_comb begin
    case (op)
      OP_LDI, OP_ADI: opnd = out_hi;
      OP_LOOP:        opnd = imm_b;
      default:        opnd = imm_a;
    endcase
  end

  assign full    = cur + opnd;
  assign sum_hi  = cur[CNT_W-1:LW] + opnd[CNT_W-1:LW];
  assign sum_lo  = cur[LW-1:0] + opnd[LW-1:0];
  assign lane_add = (hsel && lsel) ? full :
                    {hsel ? sum_hi : cur[CNT_W-1:LW], lsel ? sum_lo : cur[LW-1:0]};
  assign lane_ld  = {hsel ? opnd[CNT_W-1:LW] : cur[CNT_W-1:LW],
                     lsel ? opnd[LW-1:0]     : cur[LW-1:0]};

  assign loop_go = (op == OP_LOOP) && (cur < imm_a);
  assign nxt     = loop_go ? full : (is_add ? lane_add : lane_ld);
  assign wr      = step && (is_add || is_ld || loop_go);

  assign jump = ((op == OP_IF) && src_bit) || ((op == OP_IFN) && !src_bit) || loop_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      cnt_a <= '0;
      cnt_b <= '0;
    end else if (step) begin
      pc <= jump ? target : pc + 1'b1;
      if (wr && !csel) cnt_a <= nxt;
      if (wr && csel)  cnt_b <= nxt;
    end
  end
endmodule

module seq_ctl_unit_chk #(
  parameter int CNT_W = 16,
  parameter int PC_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic [2:0]       op,
  input logic             csel,
  input logic             hsel,
  input logic             lsel,
  input logic [CNT_W-1:0] imm_a,
  input logic [PC_W-1:0]  target,
  input logic             src_bit,
  input logic [PC_W-1:0]  pc,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] cnt_b
);
  localparam int LW = CNT_W / 2;
  logic [CNT_W-1:0] sel_cnt;
  assign sel_cnt = csel ? cnt_b : cnt_a;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(pc) && $stable(cnt_a) && $stable(cnt_b)));

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (op == 3'd0 || op == 3'd3 || op == 3'd4 || op == 3'd5 || op == 3'd7))
    |=> pc == $past(pc) + 1'b1);

  p_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ((op == 3'd1 && src_bit) || (op == 3'd2 && !src_bit))) |=> pc == $past(target));

  p_loop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == 3'd6 && sel_cnt < imm_a) |=> pc == $past(target));

  p_loop_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == 3'd6 && sel_cnt >= imm_a) |=> ($stable(cnt_a) && $stable(cnt_b)));

  p_lane_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hsel && !lsel && op != 3'd6) |=>
      ($stable(cnt_a[LW-1:0]) && $stable(cnt_b[LW-1:0])));

  p_lane_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hsel && lsel && op != 3'd6) |=>
      ($stable(cnt_a[CNT_W-1:LW]) && $stable(cnt_b[CNT_W-1:LW])));

  p_unsel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && csel) |=> $stable(cnt_a));

  p_unsel_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !csel) |=> $stable(cnt_b));
endmodule

bind seq_ctl_unit seq_ctl_unit_chk #(.CNT_W(CNT_W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .op(op), .csel(csel), .hsel(hsel),
  .lsel(lsel), .imm_a(imm_a), .target(target), .src_bit(src_bit), .pc(pc),
  .cnt_a(cnt_a), .cnt_b(cnt_b));

// File: tb/test_seq_ctl_unit.sv
`timescale 1ns/1ps
module test_seq_ctl_unit;
  logic        clk = 1'b0, rst_n = 1'b0, step = 1'b0;
  logic [2:0]  op = '0;
  logic        csel = 1'b0, hsel = 1'b0, lsel = 1'b0, src_bit = 1'b0;
  logic [15:0] imm_a = '0, imm_b = '0, out_hi = '0;
  logic [7:0]  target = '0;
  logic [7:0]  pc;
  logic [15:0] cnt_a, cnt_b;

  logic [7:0]  m_pc;
  logic [15:0] m_a, m_b;
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seq_ctl_unit i_seq_ctl_unit (
    .clk(clk), .rst_n(rst_n), .step(step), .op(op), .csel(csel), .hsel(hsel),
    .lsel(lsel), .imm_a(imm_a), .imm_b(imm_b), .target(target), .src_bit(src_bit),
    .out_hi(out_hi), .pc(pc), .cnt_a(cnt_a), .cnt_b(cnt_b));

  function automatic logic [15:0] f_counter(input logic [15:0] c, input logic [2:0] o,
      input logic h, input logic l, input logic [15:0] ia, input logic [15:0] ib,
      input logic [15:0] oh);
    logic [15:0] v;
    logic [7:0] hb, lb;
    if (o == 3'd6) return (c < ia) ? 16'(c + ib) : c;
    if (o == 3'd1 || o == 3'd2 || o == 3'd7) return c;
    v = (o == 3'd4 || o == 3'd5) ? oh : ia;
    if (o == 3'd0 || o == 3'd5) begin
      if (h && l) return 16'(c + v);
      hb = h ? 8'(c[15:8] + v[15:8]) : c[15:8];
      lb = l ? 8'(c[7:0] + v[7:0]) : c[7:0];
    end else begin
      hb = h ? v[15:8] : c[15:8];
      lb = l ? v[7:0] : c[7:0];
    end
    return {hb, lb};
  endfunction

  function automatic logic [7:0] f_pc(input logic [7:0] p, input logic [2:0] o,
      input logic s, input logic [15:0] c, input logic [15:0] ia, input logic [7:0] t);
    if ((o == 3'd1 && s) || (o == 3'd2 && !s) || (o == 3'd6 && c < ia)) return t;
    return p + 8'd1;
  endfunction

  task automatic check(input string tag);
    vectors++;
    if (pc !== m_pc || cnt_a !== m_a || cnt_b !== m_b) begin
      miscompares++;
      $display("FAIL %s: pc=%h a=%h b=%h expected pc=%h a=%h b=%h",
               tag, pc, cnt_a, cnt_b, m_pc, m_a, m_b);
    end
  endtask

  task automatic apply(input string tag, input logic st, input logic [2:0] o,
      input logic cs, input logic h, input logic l, input logic [15:0] ia,
      input logic [15:0] ib, input logic [7:0] t, input logic s, input logic [15:0] oh);
    logic [15:0] c;
    step = st; op = o; csel = cs; hsel = h; lsel = l; imm_a = ia; imm_b = ib;
    target = t; src_bit = s; out_hi = oh;
    if (st) begin
      c = cs ? m_b : m_a;
      m_pc = f_pc(m_pc, o, s, c, ia, t);
      if (cs) m_b = f_counter(c, o, h, l, ia, ib, oh);
      else    m_a = f_counter(c, o, h, l, ia, ib, oh);
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  function automatic string f_tag(input logic st, input logic [2:0] o);
    if (!st) return "R2";
    case (o)
      3'd0: return "R6";
      3'd1, 3'd2: return "R4";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R9";
      3'd6: return "R5";
      default: return "R3";
    endcase
  endfunction

  initial begin
    m_pc = '0; m_a = '0; m_b = '0;
    void'($urandom(32'd20250218));
    #3 rst_n = 1'b0;
    #20 rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    // directed corners
    apply("R7",  1, 3'd3, 0, 1, 1, 16'h1234, 0, 0, 0, 0);
    apply("R11", 1, 3'd3, 1, 1, 1, 16'hFFF0, 0, 0, 0, 0);
    apply("R6",  1, 3'd0, 1, 1, 1, 16'h0020, 0, 0, 0, 0);       // full wrap
    apply("R10", 1, 3'd0, 0, 0, 1, 16'h00F0, 0, 0, 0, 0);       // low lane no carry
    apply("R10", 1, 3'd0, 0, 1, 0, 16'hF000, 0, 0, 0, 0);       // high lane wrap
    apply("R10", 1, 3'd3, 0, 0, 0, 16'hAAAA, 0, 0, 0, 0);       // no lanes
    apply("R8",  1, 3'd4, 1, 0, 1, 0, 0, 0, 0, 16'h5A77);
    apply("R9",  1, 3'd5, 1, 1, 1, 0, 0, 0, 0, 16'h8001);
    apply("R9",  1, 3'd5, 0, 0, 1, 0, 0, 0, 0, 16'h00FF);
    apply("R4",  1, 3'd1, 0, 1, 1, 0, 0, 8'h40, 1, 0);
    apply("R4",  1, 3'd1, 0, 1, 1, 0, 0, 8'h80, 0, 0);
    apply("R4",  1, 3'd2, 0, 1, 1, 0, 0, 8'h10, 0, 0);
    apply("R2",  0, 3'd3, 0, 1, 1, 16'hFFFF, 0, 8'h99, 1, 0);
    apply("R7",  1, 3'd3, 0, 1, 1, 16'h0003, 0, 0, 0, 0);
    apply("R5",  1, 3'd6, 0, 0, 0, 16'h0005, 16'h0002, 8'h20, 0, 0); // 3<5 taken
    apply("R5",  1, 3'd6, 0, 1, 1, 16'h0005, 16'h0002, 8'h20, 0, 0); // 5<5 not taken
    apply("R5",  1, 3'd6, 1, 1, 1, 16'hFFFF, 16'h0100, 8'h30, 0, 0);
    for (int k = 0; k < 260; k++)
      apply("R3", 1, 3'd7, 0, 1, 1, 0, 0, 0, 0, 0);               // pc wrap
    for (int k = 0; k < 3000; k++) begin
      logic st; logic [2:0] o; logic [15:0] ia;
      st = ($urandom % 8) != 0;
      o  = 3'($urandom);
      ia = ($urandom % 4 == 0) ? 16'($urandom % 8) : 16'($urandom);
      apply(f_tag(st, o), st, o, 1'($urandom), 1'($urandom), 1'($urandom), ia,
            16'($urandom), 8'($urandom), 1'($urandom), 16'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule